// File: doc/BRIEF.md
# Cache Array Maintenance Port

This block gives software a register-bus window onto the storage of a small 4-way set-associative operand cache. Each way keeps a tag, a valid flag and a dirty flag for every entry. Each entry keeps one replacement-order field that is shared by its ways. Each line holds four 32-bit longwords. Through the window, software can read and load the tag array directly. It can read and write single data longwords. It can also issue an associative tag-array write: the supplied tag is matched against every way of one entry, and only the valid and dirty flags of the matching way are rewritten.

When an associative write hits a line that was dirty, the block copies that line out to memory over a separate write port. It sends four longword beats in ascending offset order, and each beat waits for the memory side to acknowledge it. While this copy-out runs, the bus stalls new requests. The block gives the maintenance view only: normal cache fills and the replacement policy sit elsewhere.

Top module: `cache_maint_port`

## Requirements
- R1: Request address decode: bit 24 picks the array (0 = tag array, 1 = data array). Bits 13:12 pick the way (00 to 11 = way 0 to way 3). Bits 7:4 pick the entry. Bits 3:2 pick the longword in a data-array access (00 to 11 = longword 0 to longword 3). Bit 3 is the associative flag in a tag-array write. Bits 1:0 are ignored.
- R2: A data-array read accepted on a clock edge drives rsp_valid high for exactly one cycle after that edge, with rsp_data holding the addressed longword.
- R3: A data-array write stores req_wdata into the addressed longword. Data-array reads and writes leave every tag, valid, dirty and replacement field unchanged.
- R4: Tag-array words use this layout: tag in bits 31:8, replacement field in bits 7:2, dirty in bit 1, valid in bit 0. A tag-array read returns the addressed way in this layout, one cycle after acceptance. A direct write (bit 3 = 0) loads the tag, valid and dirty flags of the addressed way, and the replacement field of the entry.
- R5: An associative write (bit 3 = 1) hits a way whose valid flag is 1 and whose stored tag equals wdata bits 31:8. Only the lowest-numbered hitting way takes the new valid and dirty flags from wdata bits 0 and 1. Its tag, the entry's replacement field and all other ways stay unchanged.
- R6: An associative write that hits no way changes no state, starts no write-back, and leaves req_ready high.
- R7: Whenever a valid flag is written as 0, the dirty flag of that way and entry becomes 0, whatever the dirty bit supplied.
- R8: An associative hit on a way whose dirty flag was 1 before the write emits four write-back beats. Their addresses are {stored tag, entry, longword, 00} for longwords 0, 1, 2, 3 in that order (offsets 0x0, 0x4, 0x8, 0xC). Each beat carries that longword of the line. A hit on a clean way emits no beat.
- R9: Each write-back beat holds mem_valid, mem_addr and mem_data steady until a cycle with mem_ack high. The next beat starts in the following cycle.
- R10: req_ready is low from the cycle after a dirty-hit associative write is accepted until the cycle after the last beat is acknowledged. No request is accepted during that time.
- R11: After reset, req_ready is 1, rsp_valid and mem_valid are 0, and every valid, dirty, tag and replacement field reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Request address (array, way, entry, longword, associative flag) |
| req_wdata | input | 32 | Write data / tag-array word |
| req_ready | output | 1 | Request accepted on an edge where valid and ready are both high |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_data | output | 32 | Read data |
| mem_valid | output | 1 | Write-back beat present |
| mem_addr | output | 32 | Write-back beat address |
| mem_data | output | 32 | Write-back beat data |
| mem_ack | input | 1 | Memory accepts the current beat |

## Verification
The bench aims at the associative write first. It covers a miss, a clean hit, a dirty hit that clears the valid flag, and two ways that hold the same tag. A design that compared the tag without the valid flag, took the wrong way on a double hit, disturbed the tag or replacement field, or missed the rule that clears the dirty flag would show the wrong tag-array word on read-back. On write-back, the bench checks beat order, addresses and data under both an every-cycle acknowledge and a sparse one. A sequencer that skipped beats, advanced without an acknowledge, or left the bus open during the copy-out would differ from the model within a cycle. Ignored low address bits and the fact that data accesses leave the tag array alone are also checked at the ports.

// File: rtl/cmaint_pkg.sv
package cmaint_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_TAG_RD,
    OP_TAG_WR,
    OP_TAG_ASSOC,
    OP_DAT_RD,
    OP_DAT_WR
  } op_e;

endpackage

// File: rtl/cmaint_tag_store.sv
module cmaint_tag_store #(
  parameter int WAYS    = 4,
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 24,
  parameter int LRU_W   = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [$clog2(ENTRIES)-1:0]   idx,
  input  logic [$clog2(WAYS)-1:0]      way,
  input  logic                         wr_en,
  input  logic                         as_en,
  input  logic [TAG_W-1:0]             in_tag,
  input  logic [LRU_W-1:0]             in_lru,
  input  logic                         in_v,
  input  logic                         in_u,
  output logic [TAG_W-1:0]             rd_tag,
  output logic [LRU_W-1:0]             rd_lru,
  output logic                         rd_v,
  output logic                         rd_u,
  output logic                         hit_any,
  output logic [$clog2(WAYS)-1:0]      hit_way,
  output logic                         hit_dirty,
  output logic [TAG_W-1:0]             hit_tag
);

  localparam int WAY_W = $clog2(WAYS);

  logic [WAYS-1:0][TAG_W-1:0] way_tag;
  logic [WAYS-1:0]            way_v;
  logic [WAYS-1:0]            way_u;
  logic [WAYS-1:0]            match;
  logic [WAYS-1:0]            hit_oh;
  logic                       new_v;
  logic                       new_u;
  logic [LRU_W-1:0]           lru_q [ENTRIES];

  // valid written as 0 always clears dirty
  assign new_v = in_v;
  assign new_u = in_v & in_u;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    localparam logic [WAY_W-1:0] WID = WAY_W'(w);
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [ENTRIES-1:0] v_q;
    logic [ENTRIES-1:0] u_q;
    logic               upd_en;

    assign upd_en = (wr_en && (way == WID)) || (as_en && hit_oh[w]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= '0;
        u_q <= '0;
        for (int e = 0; e < ENTRIES; e++) tag_q[e] <= '0;
      end else if (upd_en) begin
        v_q[idx] <= new_v;
        u_q[idx] <= new_u;
        if (wr_en) tag_q[idx] <= in_tag;
      end
    end

    assign way_tag[w] = tag_q[idx];
    assign way_v[w]   = v_q[idx];
    assign way_u[w]   = u_q[idx];
    assign match[w]   = v_q[idx] && (tag_q[idx] == in_tag);
  end

  // lowest-numbered matching way wins
  always_comb begin
    hit_any = 1'b0;
    hit_way = '0;
    hit_oh  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w] && !hit_any) begin
        hit_any   = 1'b1;
        hit_way   = WAY_W'(w);
        hit_oh[w] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) lru_q[e] <= '0;
    end else if (wr_en) begin
      lru_q[idx] <= in_lru;
    end
  end

  assign rd_tag    = way_tag[way];
  assign rd_v      = way_v[way];
  assign rd_u      = way_u[way];
  assign rd_lru    = lru_q[idx];
  assign hit_dirty = way_u[hit_way];
  assign hit_tag   = way_tag[hit_way];

endmodule

// File: rtl/cmaint_data_store.sv
module cmaint_data_store #(
  parameter int WAYS       = 4,
  parameter int ENTRIES    = 16,
  parameter int LINE_WORDS = 4,
  parameter int DATA_W     = 32,
  localparam int DEPTH     = WAYS * ENTRIES * LINE_WORDS,
  localparam int A_W       = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [A_W-1:0]    waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [A_W-1:0]    raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/cmaint_wb_seq.sv
module cmaint_wb_seq #(
  parameter int WAYS       = 4,
  parameter int ENTRIES    = 16,
  parameter int LINE_WORDS = 4,
  parameter int TAG_W      = 24
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [TAG_W-1:0]              start_tag,
  input  logic [$clog2(ENTRIES)-1:0]    start_idx,
  input  logic [$clog2(WAYS)-1:0]       start_way,
  input  logic                          mem_ack,
  output logic                          busy,
  output logic [$clog2(LINE_WORDS)-1:0] beat,
  output logic [TAG_W-1:0]              cur_tag,
  output logic [$clog2(ENTRIES)-1:0]    cur_idx,
  output logic [$clog2(WAYS)-1:0]       cur_way
);

  localparam int LW_W = $clog2(LINE_WORDS);
  localparam logic [LW_W-1:0] LAST = LW_W'(LINE_WORDS - 1);

  logic            busy_q, busy_d;
  logic [LW_W-1:0] beat_q, beat_d;
  logic            ld_en;

  assign ld_en = start && !busy_q;

  always_comb begin
    busy_d = busy_q;
    beat_d = beat_q;
    if (busy_q) begin
      if (mem_ack) begin
        if (beat_q == LAST) begin
          busy_d = 1'b0;
          beat_d = '0;
        end else begin
          beat_d = beat_q + 1'b1;
        end
      end
    end else if (start) begin
      busy_d = 1'b1;
      beat_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      beat_q <= '0;
    end else begin
      busy_q <= busy_d;
      beat_q <= beat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_tag <= '0;
      cur_idx <= '0;
      cur_way <= '0;
    end else if (ld_en) begin
      cur_tag <= start_tag;
      cur_idx <= start_idx;
      cur_way <= start_way;
    end
  end

  assign busy = busy_q;
  assign beat = beat_q;

endmodule

// File: rtl/cache_maint_port.sv
module cache_maint_port
  import cmaint_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int WAYS       = 4,
  parameter int ENTRIES    = 16,
  parameter int LINE_WORDS = 4,
  parameter int REGION_BIT = 24,
  parameter int ASSOC_BIT  = 3,
  parameter int WAY_LSB    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  input  logic              mem_ack
);

  localparam int WAY_W = $clog2(WAYS);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int LW_W  = $clog2(LINE_WORDS);
  localparam int OFF_W = LW_W + 2;
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int LRU_W = DATA_W - TAG_W - 2;
  localparam int DA_W  = WAY_W + IDX_W + LW_W;

  // request decode
  op_e              op;
  logic             accept;
  logic [WAY_W-1:0] way_f;
  logic [IDX_W-1:0] idx_f;
  logic [LW_W-1:0]  lw_f;
  logic             unused_addr;

  assign accept      = req_valid && req_ready;
  assign way_f       = req_addr[WAY_LSB +: WAY_W];
  assign idx_f       = req_addr[OFF_W +: IDX_W];
  assign lw_f        = req_addr[2 +: LW_W];
  assign unused_addr = ^req_addr;

  always_comb begin
    op = OP_NONE;
    if (accept) begin
      unique case ({req_addr[REGION_BIT], req_write})
        2'b00:   op = OP_TAG_RD;
        2'b01:   op = req_addr[ASSOC_BIT] ? OP_TAG_ASSOC : OP_TAG_WR;
        2'b10:   op = OP_DAT_RD;
        default: op = OP_DAT_WR;
      endcase
    end
  end

  // tag array
  logic [TAG_W-1:0] rd_tag, hit_tag;
  logic [LRU_W-1:0] rd_lru;
  logic             rd_v, rd_u, hit_any, hit_dirty;
  logic [WAY_W-1:0] hit_way;

  cmaint_tag_store #(
    .WAYS(WAYS), .ENTRIES(ENTRIES), .TAG_W(TAG_W), .LRU_W(LRU_W)
  ) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx       (idx_f),
    .way       (way_f),
    .wr_en     (op == OP_TAG_WR),
    .as_en     (op == OP_TAG_ASSOC),
    .in_tag    (req_wdata[DATA_W-1 -: TAG_W]),
    .in_lru    (req_wdata[2 +: LRU_W]),
    .in_v      (req_wdata[0]),
    .in_u      (req_wdata[1]),
    .rd_tag    (rd_tag),
    .rd_lru    (rd_lru),
    .rd_v      (rd_v),
    .rd_u      (rd_u),
    .hit_any   (hit_any),
    .hit_way   (hit_way),
    .hit_dirty (hit_dirty),
    .hit_tag   (hit_tag)
  );

  // write-back sequencer
  logic             wb_busy, wb_start;
  logic [LW_W-1:0]  wb_beat;
  logic [TAG_W-1:0] wb_tag;
  logic [IDX_W-1:0] wb_idx;
  logic [WAY_W-1:0] wb_way;

  assign wb_start = (op == OP_TAG_ASSOC) && hit_any && hit_dirty;

  cmaint_wb_seq #(
    .WAYS(WAYS), .ENTRIES(ENTRIES), .LINE_WORDS(LINE_WORDS), .TAG_W(TAG_W)
  ) u_wb (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (wb_start),
    .start_tag (hit_tag),
    .start_idx (idx_f),
    .start_way (hit_way),
    .mem_ack   (mem_ack),
    .busy      (wb_busy),
    .beat      (wb_beat),
    .cur_tag   (wb_tag),
    .cur_idx   (wb_idx),
    .cur_way   (wb_way)
  );

  // data array, read port shared between bus and write-back
  logic [DA_W-1:0]   da_req, da_raddr;
  logic [DATA_W-1:0] da_rdata;

  assign da_req   = {way_f, idx_f, lw_f};
  assign da_raddr = wb_busy ? {wb_way, wb_idx, wb_beat} : da_req;

  cmaint_data_store #(
    .WAYS(WAYS), .ENTRIES(ENTRIES), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)
  ) u_data (
    .clk   (clk),
    .we    (op == OP_DAT_WR),
    .waddr (da_req),
    .wdata (req_wdata),
    .raddr (da_raddr),
    .rdata (da_rdata)
  );

  // read response
  logic              rsp_valid_d, rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_d, rsp_data_q;

  always_comb begin
    rsp_valid_d = (op == OP_TAG_RD) || (op == OP_DAT_RD);
    rsp_data_d  = (op == OP_TAG_RD) ? {rd_tag, rd_lru, rd_u, rd_v} : da_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      if (rsp_valid_d) rsp_data_q <= rsp_data_d;
    end
  end

  assign req_ready = !wb_busy;
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign mem_valid = wb_busy;
  assign mem_addr  = {wb_tag, wb_idx, wb_beat, 2'b00};
  assign mem_data  = da_rdata;

endmodule

// File: rtl/cache_maint_port_chk.sv
module cache_maint_port_chk #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic              mem_ack
);

  localparam int LW_W  = $clog2(LINE_WORDS);
  localparam int OFF_W = LW_W + 2;
  localparam logic [LW_W-1:0] LAST = LW_W'(LINE_WORDS - 1);

  logic [LW_W-1:0] beat;
  assign beat = mem_addr[2 +: LW_W];

  p_beat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ack |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

  p_first_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> beat == '0);

  p_next_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ack && beat != LAST |=> mem_valid
      && beat == LW_W'($past(beat) + 1'b1)
      && mem_addr[ADDR_W-1:OFF_W] == $past(mem_addr[ADDR_W-1:OFF_W]));

  p_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[1:0] == 2'b00);

  p_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ack && beat == LAST |=> !mem_valid && req_ready);

  p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready);

  p_rsp_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready));

endmodule

bind cache_maint_port cache_maint_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_valid (mem_valid),
  .mem_addr  (mem_addr),
  .mem_data  (mem_data),
  .mem_ack   (mem_ack)
);

// File: tb/tb_cache_maint_port.sv
module tb_cache_maint_port;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [31:0] req_addr, req_wdata;
  logic        req_ready, rsp_valid, mem_valid, mem_ack;
  logic [31:0] rsp_data, mem_addr, mem_data;

  int total = 0;
  int bad   = 0;
  bit ack_slow = 1'b0;
  int ack_cnt = 0;

  cache_maint_port dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_ack(mem_ack)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  logic [23:0] m_tag [4][16];
  logic        m_v   [4][16];
  logic        m_u   [4][16];
  logic [5:0]  m_lru [16];
  logic [31:0] m_dat [4][16][4];
  logic        m_busy;
  int          m_beat, m_widx, m_wway;
  logic [23:0] m_wtag;
  logic        m_rv;
  logic [31:0] m_rd;
  string       m_lbl;

  task automatic model_op();
    int w, i, l, hw;
    logic dirty;
    w = int'(req_addr[13:12]);
    i = int'(req_addr[7:4]);
    l = int'(req_addr[3:2]);
    if (!req_addr[24]) begin
      if (!req_write) begin
        m_rv = 1'b1; m_lbl = "R4";
        m_rd = {m_tag[w][i], m_lru[i], m_u[w][i], m_v[w][i]};
      end else if (!req_addr[3]) begin
        m_tag[w][i] = req_wdata[31:8];
        m_lru[i]    = req_wdata[7:2];
        m_v[w][i]   = req_wdata[0];
        m_u[w][i]   = req_wdata[0] & req_wdata[1];
      end else begin
        hw = -1;
        for (int k = 0; k < 4; k++)
          if (hw < 0 && m_v[k][i] && m_tag[k][i] == req_wdata[31:8]) hw = k;
        if (hw >= 0) begin
          dirty = m_u[hw][i];
          m_v[hw][i] = req_wdata[0];
          m_u[hw][i] = req_wdata[0] & req_wdata[1];
          if (dirty) begin
            m_busy = 1'b1; m_beat = 0; m_wtag = m_tag[hw][i];
            m_widx = i; m_wway = hw;
          end
        end
      end
    end else if (!req_write) begin
      m_rv = 1'b1; m_lbl = "R2"; m_rd = m_dat[w][i][l];
    end else begin
      m_dat[w][i][l] = req_wdata;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < 4; w++)
        for (int i = 0; i < 16; i++) begin
          m_tag[w][i] = '0; m_v[w][i] = 1'b0; m_u[w][i] = 1'b0;
        end
      for (int i = 0; i < 16; i++) m_lru[i] = '0;
      m_busy = 1'b0; m_beat = 0; m_rv = 1'b0; m_rd = '0; m_lbl = "R2";
      m_wtag = '0; m_widx = 0; m_wway = 0;
    end else begin
      m_rv = 1'b0;
      if (m_busy) begin
        if (mem_ack) begin
          if (m_beat == 3) m_busy = 1'b0;
          else m_beat++;
        end
      end else if (req_valid) begin
        model_op();
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(req_ready === !m_busy, "R10 req_ready", 32'(req_ready), 32'(!m_busy));
      chk(rsp_valid === m_rv, "R2 rsp_valid", 32'(rsp_valid), 32'(m_rv));
      if (m_rv) chk(rsp_data === m_rd, m_lbl, rsp_data, m_rd);
      chk(mem_valid === m_busy, "R8 mem_valid", 32'(mem_valid), 32'(m_busy));
      if (m_busy) begin
        chk(mem_addr === {m_wtag, m_widx[3:0], m_beat[1:0], 2'b00}, "R8 mem_addr",
            mem_addr, {m_wtag, m_widx[3:0], m_beat[1:0], 2'b00});
        chk(mem_data === m_dat[m_wway][m_widx][m_beat], "R8 mem_data",
            mem_data, m_dat[m_wway][m_widx][m_beat]);
      end
    end
  end

  // memory acknowledge pattern
  always @(negedge clk) begin
    ack_cnt++;
    mem_ack <= ack_slow ? (ack_cnt % 3 == 0) : 1'b1;
  end

  // beat log
  logic [31:0] log_addr [$];
  logic [31:0] log_data [$];
  always @(posedge clk) begin
    if (rst_n && mem_valid && mem_ack) begin
      log_addr.push_back(mem_addr);
      log_data.push_back(mem_data);
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [31:0] da(input int w, input int i, input int l);
    return 32'h0100_0000 | (w << 12) | (i << 4) | (l << 2);
  endfunction

  function automatic logic [31:0] ta(input int w, input int i, input bit assoc);
    return (w << 12) | (i << 4) | (assoc ? 32'h8 : 32'h0);
  endfunction

  function automatic logic [31:0] tw(input logic [23:0] t, input logic [5:0] lru,
                                     input bit u, input bit v);
    return {t, lru, u, v};
  endfunction

  task automatic bus(input bit wr, input logic [31:0] a, input logic [31:0] d,
                     output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    rd = rsp_data;
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (mem_valid) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    chk(1'b0, "watchdog", 32'(total), 32'(0));
    finish_run();
  end

  initial begin
    logic [31:0] r;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    mem_ack = 1'b1;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset state
    chk(req_ready === 1'b1, "R11 ready", 32'(req_ready), 32'(1));
    chk(rsp_valid === 1'b0, "R11 rsp_valid", 32'(rsp_valid), 32'(0));
    chk(mem_valid === 1'b0, "R11 mem_valid", 32'(mem_valid), 32'(0));
    bus(1'b0, ta(2, 5, 0), '0, r);
    chk(r === 32'h0, "R11 tag word", r, 32'h0);

    // R3: data writes to way1 entry3, way0 entry9
    for (int k = 0; k < 4; k++) bus(1'b1, da(1, 3, k), 32'hD000_0100 + k * 17, r);
    for (int k = 0; k < 4; k++) bus(1'b1, da(0, 9, k), 32'h5A00_0000 + k * 3, r);
    bus(1'b0, da(1, 3, 2), '0, r);
    chk(r === 32'hD000_0122, "R3 data readback", r, 32'hD000_0122);
    // R1: low address bits ignored
    bus(1'b0, da(1, 3, 0) | 32'h3, '0, r);
    chk(r === 32'hD000_0100, "R1 low bits ignored", r, 32'hD000_0100);
    // R3: tag array untouched by data access
    bus(1'b0, ta(1, 3, 0), '0, r);
    chk(r === 32'h0, "R3 tag untouched", r, 32'h0);

    // R4: direct tag writes
    bus(1'b1, ta(1, 3, 0), tw(24'hABCDEF, 6'h2A, 1, 1), r);
    bus(1'b0, ta(1, 3, 0), '0, r);
    chk(r === tw(24'hABCDEF, 6'h2A, 1, 1), "R4 tag readback", r, tw(24'hABCDEF, 6'h2A, 1, 1));
    bus(1'b1, ta(2, 3, 0), tw(24'h111111, 6'h15, 0, 1), r);
    // R7: V=0 clears U on direct write
    bus(1'b1, ta(0, 3, 0), tw(24'h222222, 6'h15, 1, 0), r);
    bus(1'b0, ta(0, 3, 0), '0, r);
    chk(r === tw(24'h222222, 6'h15, 0, 0), "R7 direct clear", r, tw(24'h222222, 6'h15, 0, 0));

    // R6: associative miss (way0 tag matches but V=0)
    bus(1'b1, ta(0, 3, 1), tw(24'h222222, 6'h00, 1, 1), r);
    chk(req_ready === 1'b1 && mem_valid === 1'b0, "R6 miss no stall",
        {req_ready, mem_valid}, 32'h2);
    bus(1'b0, ta(0, 3, 0), '0, r);
    chk(r === tw(24'h222222, 6'h15, 0, 0), "R6 miss no write", r, tw(24'h222222, 6'h15, 0, 0));

    // R5: clean hit on way2, LRU and tag unchanged
    bus(1'b1, ta(0, 3, 1), tw(24'h111111, 6'h3F, 1, 1), r);
    bus(1'b0, ta(2, 3, 0), '0, r);
    chk(r === tw(24'h111111, 6'h15, 1, 1), "R5 clean hit", r, tw(24'h111111, 6'h15, 1, 1));
    chk(log_addr.size() == 0, "R8 no beat on clean", 32'(log_addr.size()), 32'(0));

    // R8, R9, R10: dirty hit on way1 with V=0, sparse ack
    ack_slow = 1'b1;
    bus(1'b1, ta(3, 3, 1), tw(24'hABCDEF, 6'h00, 1, 0), r);
    chk(req_ready === 1'b0 && mem_valid === 1'b1, "R10 stall during copy-out",
        {req_ready, mem_valid}, 32'h1);
    wait_idle();
    chk(req_ready === 1'b1, "R10 ready after copy-out", 32'(req_ready), 32'(1));
    chk(log_addr.size() == 4, "R8 beat count", 32'(log_addr.size()), 32'(4));
    for (int k = 0; k < 4 && k < log_addr.size(); k++) begin
      chk(log_addr[k] === 32'hABCDEF30 + k * 4, "R8 beat addr", log_addr[k], 32'hABCDEF30 + k * 4);
      chk(log_data[k] === 32'hD000_0100 + k * 17, "R9 beat data", log_data[k], 32'hD000_0100 + k * 17);
    end
    log_addr.delete(); log_data.delete();
    bus(1'b0, ta(1, 3, 0), '0, r);
    chk(r === tw(24'hABCDEF, 6'h15, 0, 0), "R7 assoc clear keeps tag", r, tw(24'hABCDEF, 6'h15, 0, 0));

    // R5: double hit on entry9, lowest way wins
    ack_slow = 1'b0;
    bus(1'b1, ta(3, 9, 0), tw(24'h333333, 6'h15, 0, 1), r);
    bus(1'b1, ta(0, 9, 0), tw(24'h333333, 6'h15, 0, 1), r);
    bus(1'b1, ta(0, 9, 1), tw(24'h333333, 6'h00, 1, 1), r);
    bus(1'b0, ta(0, 9, 0), '0, r);
    chk(r === tw(24'h333333, 6'h15, 1, 1), "R5 lowest way hit", r, tw(24'h333333, 6'h15, 1, 1));
    bus(1'b0, ta(3, 9, 0), '0, r);
    chk(r === tw(24'h333333, 6'h15, 0, 1), "R5 other way kept", r, tw(24'h333333, 6'h15, 0, 1));

    // R8, R9: dirty hit kept valid, ack every cycle; read queued behind it
    bus(1'b1, ta(2, 9, 1), tw(24'h333333, 6'h00, 1, 1), r);
    bus(1'b0, da(0, 9, 3), '0, r);
    chk(r === 32'h5A00_0009, "R10 read after copy-out", r, 32'h5A00_0009);
    chk(log_addr.size() == 4, "R8 beat count fast", 32'(log_addr.size()), 32'(4));
    for (int k = 0; k < 4 && k < log_addr.size(); k++)
      chk(log_addr[k] === 32'h33333390 + k * 4, "R8 beat addr fast", log_addr[k], 32'h33333390 + k * 4);
    bus(1'b0, ta(0, 9, 0), '0, r);
    chk(r === tw(24'h333333, 6'h15, 1, 1), "R5 flags rewritten", r, tw(24'h333333, 6'h15, 1, 1));

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule